// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the serial slave side of a small behavioural SPI NOR flash model. It watches the chip-select, serial clock and serial data pins from a fast system clock. It builds 8-bit instruction bytes and 24-bit addresses, and shifts read data or identification bytes back out on the serial output. Array reads come from a small RAM window. A separate write port fills that window.

It serves four read-type instructions itself: plain read, fast read with one dummy byte, a three-byte JEDEC identification readout, and a two-byte identification readout that alternates manufacturer and device codes. Any other opcode is forwarded. The front-end collects up to four bytes that follow the opcode. When chip-select is released, it presents them to a status/protection unit through a request/grant handshake. That unit owns program, erase and status behaviour.

Top module: `spi_flash_frontend`

## Requirements
- R1: Both SPI mode 0 (SCK idle low) and mode 3 (SCK idle high) are accepted. SI is sampled on each rising SCK edge while CE# is low, and every byte is taken MSB first.
- R2: Opcode 03h followed by three address bytes (A23 first) makes SO output the byte at that address MSB first. SO changes on falling SCK edges, starting at the first falling edge after the last address bit.
- R3: Opcode 0Bh takes three address bytes and then one dummy byte of any value. Only after the dummy byte does data output start, in the same way as R2.
- R4: Read data continues with the next address after every byte, for as long as CE# stays low. The address wraps from 2^ADDR_BITS-1 back to 0.
- R5: Opcode 9Fh outputs BFh, 25h, 8Eh in that order, right after the opcode. If clocking continues, the output repeats from BFh.
- R6: Opcodes 90h and ABh take three address bytes. When A0 is 0 the output is BFh, 8Eh, BFh, ... and when A0 is 1 it is 8Eh, BFh, 8Eh, ...
- R7: `so_oe` is 0 whenever CE# is high, and during every opcode, address and dummy bit.
- R8: CE# going high at any point abandons the instruction and clears the bit count. The next instruction is decoded correctly even if the previous one stopped mid-byte.
- R9: Any other opcode is forwarded when CE# rises. `req_valid` goes to 1 with `req_opcode` set to the opcode. `req_payload` holds the first up to four complete bytes that followed the opcode, right-aligned, with the earliest byte most significant. `req_nbytes` gives how many bytes were taken, 0 to 4. These stay stable until a cycle with `req_grant` at 1, after which `req_valid` returns to 0.
- R10: A forwarded instruction that completes while `req_valid` is 1 is discarded, and the pending request is unchanged.
- R11: After reset, `so_oe` and `req_valid` are 0.
- R12: A cycle with `wr_en` at 1 stores `wr_data` at `wr_addr` of the array window, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| wr_en | input | 1 | Array window write strobe |
| wr_addr | input | ADDR_BITS | Array window write address |
| wr_data | input | 8 | Array window write data |
| req_valid | output | 1 | Forwarded instruction pending |
| req_opcode | output | 8 | Opcode of the forwarded instruction |
| req_payload | output | 32 | Bytes that followed the opcode, right-aligned |
| req_nbytes | output | 3 | Number of payload bytes, 0 to 4 |
| req_grant | input | 1 | Acceptance of the pending request |

## Verification
The checks assume the serial pins are slow compared with `clk`. Each SCK half period and each CE# setup or release lasts at least four system clocks, so the two-stage synchronizer and the edge detector see every transition. SI must be steady around each rising SCK edge. The bench meets these assumptions by using six-clock SCK half periods and four-clock CE# setup. It keeps CE# high for six clocks between instructions and changes SI together with the falling SCK edge. It also raises `req_grant` only for single cycles while a request is pending.

// File: rtl/sfe_pkg.sv
// Shared types for the SPI flash front-end.
// Assumes: opcode values are fixed by the serial protocol.
package sfe_pkg;
    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_OUT,
        PH_PASS
    } phase_t;

    typedef enum logic [1:0] {
        K_READ,
        K_FAST,
        K_JEDEC,
        K_PAIR
    } kind_t;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FAST   = 8'h0B;
    localparam logic [7:0] OP_JEDEC  = 8'h9F;
    localparam logic [7:0] OP_PAIR_A = 8'h90;
    localparam logic [7:0] OP_PAIR_B = 8'hAB;
endpackage

// File: rtl/sfe_pin_sync.sv
// Brings sck, cs_n and si into the clk domain through an equal-depth
// synchronizer chain and flags SCK edges.
// Assumes: each pin level lasts longer than STAGES+1 clk cycles.
module sfe_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    localparam int LAST = STAGES - 1;

    logic [2:0] pipe [STAGES];
    logic       sck_prev;

    // Shift the pin triple {sck, cs_n, si} through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b010;
            sck_prev <= 1'b0;
        end else begin
            pipe[0] <= {sck, cs_n, si};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sck_prev <= pipe[LAST][2];
        end
    end

    // Decode the synchronized levels into select and edge strobes.
    always_comb begin
        sel      = ~pipe[LAST][1];
        si_s     = pipe[LAST][0];
        sck_rise = pipe[LAST][2] & ~sck_prev;
        sck_fall = ~pipe[LAST][2] & sck_prev;
    end
endmodule

// File: rtl/sfe_cmd_decode.sv
// Assembles input bytes on rising SCK and walks the instruction phases.
// Holds the start address for reads and the payload of forwarded opcodes.
// Assumes: sel low clears every phase (abort on deselect).
module sfe_cmd_decode
    import sfe_pkg::*;
#(
    parameter int ADDR_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 rise,
    input  logic                 si_s,
    output phase_t               phase,
    output kind_t                kind,
    output logic [ADDR_BITS-1:0] addr,
    output logic [7:0]           pass_op,
    output logic [31:0]          payload,
    output logic [2:0]           nbytes
);
    localparam int         ADDR_BYTES = 3;
    localparam int         MAX_PAY    = 4;
    localparam logic [1:0] LAST_ADDR  = 2'(ADDR_BYTES - 1);

    logic [2:0] bitcnt;
    logic [6:0] shin;
    logic [1:0] acnt;
    logic [7:0] in_byte;

    // Byte under assembly including the bit sampled on this edge.
    always_comb in_byte = {shin, si_s};

    // Bit counter, shift register and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bitcnt  <= '0;
            shin    <= '0;
            acnt    <= '0;
            phase   <= PH_OPC;
            kind    <= K_READ;
            addr    <= '0;
            pass_op <= '0;
            payload <= '0;
            nbytes  <= '0;
        end else if (rise) begin
            bitcnt <= bitcnt + 3'd1;
            shin   <= {shin[5:0], si_s};
            if (bitcnt == 3'd7) begin
                case (phase)
                    PH_OPC: begin
                        acnt <= '0;
                        case (in_byte)
                            OP_READ:   begin kind <= K_READ;  phase <= PH_ADDR; end
                            OP_FAST:   begin kind <= K_FAST;  phase <= PH_ADDR; end
                            OP_JEDEC:  begin kind <= K_JEDEC; phase <= PH_OUT;  end
                            OP_PAIR_A,
                            OP_PAIR_B: begin kind <= K_PAIR;  phase <= PH_ADDR; end
                            default: begin
                                phase   <= PH_PASS;
                                pass_op <= in_byte;
                                payload <= '0;
                                nbytes  <= '0;
                            end
                        endcase
                    end
                    PH_ADDR: begin
                        addr <= ADDR_BITS'({addr, in_byte});
                        acnt <= acnt + 2'd1;
                        if (acnt == LAST_ADDR)
                            phase <= (kind == K_FAST) ? PH_DUMMY : PH_OUT;
                    end
                    PH_DUMMY: phase <= PH_OUT;
                    PH_PASS: begin
                        if (nbytes < 3'(MAX_PAY)) begin
                            payload <= {payload[23:0], in_byte};
                            nbytes  <= nbytes + 3'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfe_out_shift.sv
// Drives SO on falling SCK during the output phase: array bytes with
// an incrementing, wrapping pointer, or identification bytes.
// Assumes: phase and start address are stable once output starts.
module sfe_out_shift
    import sfe_pkg::*;
#(
    parameter int         ADDR_BITS = 8,
    parameter logic [7:0] MFR_ID    = 8'hBF,
    parameter logic [7:0] TYPE_ID   = 8'h25,
    parameter logic [7:0] DEV_ID    = 8'h8E
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 fall,
    input  phase_t               phase,
    input  kind_t                kind,
    input  logic [ADDR_BITS-1:0] start_addr,
    input  logic [7:0]           rd_data,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic                 so,
    output logic                 so_oe
);
    logic [ADDR_BITS-1:0] ptr, cur_ptr;
    logic [1:0]           idx, cur_idx, nxt_idx;
    logic [7:0]           nxt;
    logic [2:0]           obit;
    logic [6:0]           oshift;
    logic                 active;

    // Pick the next byte to send and advance the ID index.
    always_comb begin
        cur_ptr = active ? ptr : start_addr;
        if (active)             cur_idx = idx;
        else if (kind == K_PAIR) cur_idx = {1'b0, start_addr[0]};
        else                    cur_idx = 2'd0;
        case (kind)
            K_JEDEC: begin
                nxt     = (cur_idx == 2'd0) ? MFR_ID :
                          (cur_idx == 2'd1) ? TYPE_ID : DEV_ID;
                nxt_idx = (cur_idx == 2'd2) ? 2'd0 : cur_idx + 2'd1;
            end
            K_PAIR: begin
                nxt     = cur_idx[0] ? DEV_ID : MFR_ID;
                nxt_idx = {1'b0, ~cur_idx[0]};
            end
            default: begin
                nxt     = rd_data;
                nxt_idx = cur_idx;
            end
        endcase
        rd_addr = cur_ptr;
    end

    // Output shifter: load a byte every eighth falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            idx    <= '0;
            obit   <= '0;
            oshift <= '0;
            active <= 1'b0;
            so     <= 1'b0;
            so_oe  <= 1'b0;
        end else if (!sel) begin
            obit   <= '0;
            oshift <= '0;
            active <= 1'b0;
            so_oe  <= 1'b0;
        end else if (fall && phase == PH_OUT) begin
            so_oe <= 1'b1;
            obit  <= obit + 3'd1;
            if (obit == 3'd0) begin
                so     <= nxt[7];
                oshift <= nxt[6:0];
                ptr    <= cur_ptr + ADDR_BITS'(1);
                idx    <= nxt_idx;
                active <= 1'b1;
            end else begin
                so     <= oshift[6];
                oshift <= {oshift[5:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sfe_ram_window.sv
// Behavioural byte array: one synchronous write port, one
// combinational read port.
// Assumes: contents are loaded through the write port before use.
module sfe_ram_window #(
    parameter int ADDR_BITS = 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [7:0]           rd_data
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [7:0] mem [DEPTH];

    // Store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the addressed byte.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/sfe_handoff.sv
// Turns a completed forwarded instruction into a held request and
// clears it on grant.
// Assumes: the decoder still shows the phase in the first deselected cycle.
module sfe_handoff
    import sfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  phase_t      phase,
    input  logic [7:0]  pass_op,
    input  logic [31:0] payload,
    input  logic [2:0]  nbytes,
    input  logic        req_grant,
    output logic        req_valid,
    output logic [7:0]  req_opcode,
    output logic [31:0] req_payload,
    output logic [2:0]  req_nbytes
);
    logic sel_d;

    // Capture on deselect, release on grant, drop while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_d       <= 1'b0;
            req_valid   <= 1'b0;
            req_opcode  <= '0;
            req_payload <= '0;
            req_nbytes  <= '0;
        end else begin
            sel_d <= sel;
            if (req_valid && req_grant) begin
                req_valid <= 1'b0;
            end else if (!req_valid && sel_d && !sel && phase == PH_PASS) begin
                req_valid   <= 1'b1;
                req_opcode  <= pass_op;
                req_payload <= payload;
                req_nbytes  <= nbytes;
            end
        end
    end
endmodule

// File: rtl/spi_flash_frontend.sv
// Top of the SPI flash serial front-end: pin sync, decoder, output
// shifter, array window and request handoff.
// Assumes: clk is much faster than sck (see brief).
module spi_flash_frontend
    import sfe_pkg::*;
#(
    parameter int         ADDR_BITS   = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MFR_ID      = 8'hBF,
    parameter logic [7:0] TYPE_ID     = 8'h25,
    parameter logic [7:0] DEV_ID      = 8'h8E
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 si,
    output logic                 so,
    output logic                 so_oe,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [7:0]           wr_data,
    output logic                 req_valid,
    output logic [7:0]           req_opcode,
    output logic [31:0]          req_payload,
    output logic [2:0]           req_nbytes,
    input  logic                 req_grant
);
    logic                 sel, sck_rise, sck_fall, si_s;
    phase_t               phase;
    kind_t                kind;
    logic [ADDR_BITS-1:0] start_addr, rd_addr;
    logic [7:0]           rd_data, pass_op;
    logic [31:0]          payload;
    logic [2:0]           nbytes;

    sfe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
    );

    sfe_cmd_decode #(.ADDR_BITS(ADDR_BITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rise(sck_rise), .si_s(si_s),
        .phase(phase), .kind(kind), .addr(start_addr),
        .pass_op(pass_op), .payload(payload), .nbytes(nbytes)
    );

    sfe_out_shift #(
        .ADDR_BITS(ADDR_BITS), .MFR_ID(MFR_ID), .TYPE_ID(TYPE_ID), .DEV_ID(DEV_ID)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .sel(sel), .fall(sck_fall),
        .phase(phase), .kind(kind), .start_addr(start_addr),
        .rd_data(rd_data), .rd_addr(rd_addr), .so(so), .so_oe(so_oe)
    );

    sfe_ram_window #(.ADDR_BITS(ADDR_BITS)) u_ram (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    sfe_handoff u_hand (
        .clk(clk), .rst_n(rst_n), .sel(sel), .phase(phase),
        .pass_op(pass_op), .payload(payload), .nbytes(nbytes),
        .req_grant(req_grant), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_payload(req_payload), .req_nbytes(req_nbytes)
    );
endmodule

// File: rtl/sfe_checker.sv
// Port-level properties of the front-end, bound to the top module.
module sfe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        so,
    input logic        so_oe,
    input logic        req_valid,
    input logic [7:0]  req_opcode,
    input logic [31:0] req_payload,
    input logic [2:0]  req_nbytes,
    input logic        req_grant
);
    assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    assert_so_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> $stable(so));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_grant) |=>
            (req_valid && $stable(req_opcode) && $stable(req_payload) && $stable(req_nbytes)));

    assert_grant_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_grant) |=> !req_valid);

    assert_nbytes_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_nbytes <= 3'd4));
endmodule

bind spi_flash_frontend sfe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .so_oe(so_oe),
    .req_valid(req_valid), .req_opcode(req_opcode), .req_payload(req_payload),
    .req_nbytes(req_nbytes), .req_grant(req_grant)
);

// File: tb/tb_spi_flash_frontend.sv
module tb_spi_flash_frontend;
    localparam int AW = 8;
    localparam int H  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic          so, so_oe;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          req_valid;
    logic [7:0]    req_opcode;
    logic [31:0]   req_payload;
    logic [2:0]    req_nbytes;
    logic          req_grant = 1'b0;

    int   total = 0, bad = 0;
    bit   finished = 1'b0;
    bit   mode3 = 1'b0;
    logic [7:0] model [1 << AW];

    always #10 clk = ~clk;

    spi_flash_frontend dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_payload(req_payload), .req_nbytes(req_nbytes), .req_grant(req_grant)
    );

    function automatic logic [7:0] exp_jedec(int i);
        case (i % 3)
            0: return 8'hBF;
            1: return 8'h25;
            default: return 8'h8E;
        endcase
    endfunction

    function automatic logic [7:0] exp_pair(bit a0, int i);
        return ((int'(a0) + i) % 2 == 1) ? 8'h8E : 8'hBF;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cs_begin(input bit m3);
        @(negedge clk);
        mode3 = m3;
        sck   = m3;
        repeat (2) @(negedge clk);
        cs_n  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_end();
        @(negedge clk);
        if (!mode3) sck = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    // One bit per SCK period: fall, set SI, wait, sample SO, rise, wait.
    task automatic xfer(input logic [7:0] tx, input int nbits,
                        output logic [7:0] rx, output bit oe_any);
        rx = '0;
        oe_any = 1'b0;
        for (int b = 7; b >= 8 - nbits; b--) begin
            sck = 1'b0;
            si  = tx[b];
            repeat (H) @(negedge clk);
            rx[b] = so;
            oe_any |= so_oe;
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
    endtask

    // Read-type instruction with addressing; compares every output byte.
    task automatic do_cmd(input logic [7:0] op, input logic [23:0] a,
                          input bit m3, input int len, input string req);
        logic [7:0] rx;
        bit oe, in_oe;
        logic [7:0] e;
        cs_begin(m3);
        xfer(op, 8, rx, in_oe);
        if (op != 8'h9F) begin
            for (int k = 2; k >= 0; k--) begin
                xfer(a[k*8 +: 8], 8, rx, oe);
                in_oe |= oe;
            end
        end
        if (op == 8'h0B) begin
            xfer(8'h5A, 8, rx, oe);
            in_oe |= oe;
        end
        check(!in_oe, "R7", "so_oe during input", 32'(in_oe), 0);
        for (int i = 0; i < len; i++) begin
            xfer(8'h00, 8, rx, oe);
            case (op)
                8'h9F:        e = exp_jedec(i);
                8'h90, 8'hAB: e = exp_pair(a[0], i);
                default:      e = model[(int'(a[AW-1:0]) + i) % (1 << AW)];
            endcase
            check(rx === e, req, "data byte", 32'(rx), 32'(e));
        end
        cs_end();
        check(so_oe === 1'b0, "R7", "so_oe after deselect", 32'(so_oe), 0);
    endtask

    task automatic fwd_cmd(input logic [7:0] op, input int nb, input logic [39:0] bytes);
        logic [7:0] rx;
        bit oe;
        cs_begin(1'b0);
        xfer(op, 8, rx, oe);
        for (int i = 0; i < nb; i++) xfer(bytes[(nb-1-i)*8 +: 8], 8, rx, oe);
        cs_end();
    endtask

    task automatic grant();
        @(negedge clk);
        req_grant = 1'b1;
        @(negedge clk);
        req_grant = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rx;
        bit          oe;
        logic [23:0] a;
        void'($urandom(32'h5EED1));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        check(so_oe === 1'b0, "R11", "so_oe after reset", 32'(so_oe), 0);
        check(req_valid === 1'b0, "R11", "req_valid after reset", 32'(req_valid), 0);

        // R12: load the array window through the write port.
        for (int i = 0; i < (1 << AW); i++) begin
            wr_en   = 1'b1;
            wr_addr = AW'(i);
            wr_data = 8'($urandom);
            model[i] = wr_data;
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);

        // Directed: R2 in mode 0 and R1 in mode 3, R12 readback.
        do_cmd(8'h03, 24'h000010, 1'b0, 3, "R2");
        do_cmd(8'h03, 24'h000010, 1'b1, 3, "R1");
        // R4: wrap across the top of the window.
        do_cmd(8'h03, 24'h1234FD, 1'b0, 6, "R4");
        // R3: fast read with dummy byte, both modes.
        do_cmd(8'h0B, 24'h0000FF, 1'b1, 3, "R3");
        do_cmd(8'h0B, 24'h000040, 1'b0, 2, "R3");
        // R5: JEDEC id, repeating.
        do_cmd(8'h9F, 24'h0, 1'b0, 7, "R5");
        // R6: both A0 values and both opcodes.
        do_cmd(8'h90, 24'h000000, 1'b0, 4, "R6");
        do_cmd(8'hAB, 24'h000001, 1'b1, 4, "R6");

        // R8: abort mid-opcode, then a clean JEDEC read.
        cs_begin(1'b0);
        xfer(8'h03, 3, rx, oe);
        cs_end();
        do_cmd(8'h9F, 24'h0, 1'b0, 3, "R8");
        // R8: abort mid-address, then a read.
        cs_begin(1'b1);
        xfer(8'h0B, 8, rx, oe);
        xfer(8'hFF, 5, rx, oe);
        cs_end();
        do_cmd(8'h03, 24'h000080, 1'b1, 2, "R8");

        // R9: program-style forward with four payload bytes.
        fwd_cmd(8'h02, 4, 40'h00_ABCDEF_5A);
        check(req_valid === 1'b1, "R9", "req_valid", 32'(req_valid), 1);
        check(req_opcode === 8'h02, "R9", "opcode", 32'(req_opcode), 32'h02);
        check(req_payload === 32'hABCDEF5A, "R9", "payload", req_payload, 32'hABCDEF5A);
        check(req_nbytes === 3'd4, "R9", "nbytes", 32'(req_nbytes), 4);
        // R10: a second forward while pending is dropped.
        fwd_cmd(8'h06, 0, 40'h0);
        check(req_opcode === 8'h02 && req_nbytes === 3'd4, "R10", "pending unchanged",
              32'(req_opcode), 32'h02);
        grant();
        check(req_valid === 1'b0, "R9", "cleared by grant", 32'(req_valid), 0);
        // R9: no-payload forward and an over-long forward.
        fwd_cmd(8'h06, 0, 40'h0);
        check(req_valid === 1'b1 && req_opcode === 8'h06 && req_nbytes === 3'd0,
              "R9", "zero-byte forward", {req_opcode, 21'h0, req_nbytes}, {8'h06, 24'h0});
        grant();
        fwd_cmd(8'h01, 5, 40'h11_2233_4455);
        check(req_payload === 32'h11223344 && req_nbytes === 3'd4, "R9",
              "truncated payload", req_payload, 32'h11223344);
        grant();

        // Random mix of read-type instructions.
        for (int n = 0; n < 24; n++) begin
            int sel_op;
            logic [7:0] op;
            sel_op = int'($urandom_range(0, 4));
            a = 24'($urandom);
            case (sel_op)
                0: op = 8'h03;
                1: op = 8'h0B;
                2: op = 8'h9F;
                3: op = 8'h90;
                default: op = 8'hAB;
            endcase
            do_cmd(op, a, 1'($urandom), int'($urandom_range(1, 5)),
                   (op == 8'h03) ? "R4" : (op == 8'h0B) ? "R3" : (op == 8'h9F) ? "R5" : "R6");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule